// File: doc/BRIEF.md
# Tagged Time-Stamp Transmit Queue

This block gathers 4-bit residual time stamp values for eight line ports and holds them in one first-in first-out queue. A frame generator reads the queue. Each stored entry carries the value and the number of the port it belongs to. When the frame generator starts a new frame it pops one entry and gets back both the port number and the value. The pop result is combinational and comes from the head of the queue.

Values can enter the queue from three places. The first is a receive-side loopback that sends received values from any port back into the queue. The second is a test register that a processor writes, one per port. The third is the set of per-port generators. The block grants at most one write into the queue per cycle, using a fixed priority.

Per-port controls change where generator values go. A test-enable bit silences that port's generator. A route bit sends that port's generated values out on a separate receive-path output, so they do not enter the queue. Sticky flags record overflow, underflow and every request that loses arbitration. Only reset clears these flags.

Top module: `rts_tx_queue`

## Requirements
- R1: After reset, q_empty is 1, q_full is 0, and overflow_flag, underflow_flag and every drop_flag bit are 0. A pop in the first cycle gives pop_valid 0.
- R2: When pop is high and the queue holds entries, pop_valid is 1 in that same cycle and pop_port/pop_rts show the oldest entry. That entry is removed at the next clock edge, so entries leave in the order they were written.
- R3: A granted write while 16 entries are stored does not change the stored contents or their order, even if a pop happens in the same cycle, and it sets overflow_flag. The flag stays set until reset.
- R4: A pop while the queue is empty gives pop_valid 0 and sets underflow_flag. The flag stays set until reset.
- R5: A test write (tst_wr high) to port p with test_en[p]=1 requests a write of {tst_port, tst_rts}. If it is granted, the entry can be popped from the next cycle on. A test write to a port whose test_en bit is 0 is ignored and stores nothing.
- R6: While test_en[i]=1, a value from generator i (gen_valid[i]) is discarded. It enters neither the queue nor the receive-path output.
- R7: When lb_en=1, each rx_valid requests a write of {rx_port, rx_rts}. When lb_en=0, rx_valid has no effect.
- R8: At most one entry is written per cycle. The priority order is: loopback, then test write, then generator requests with the lowest port number winning.
- R9: Every request that loses arbitration sets a sticky bit. drop_flag[i] is for generator i, covering both the queue path and the receive path. drop_flag[8] is for the test write.
- R10: When gen_to_rx_en[i]=1 and test_en[i]=0, a value from generator i goes out in the same cycle on rxp_valid/rxp_port/rxp_rts and is not queued. Among several such ports, the lowest-numbered one is sent.
- R11: q_full is 1 exactly when 16 entries are stored, and q_empty is 1 exactly when none are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_valid | input | 8 | Per-port generator value strobe |
| gen_rts | input | 32 | Generator values, port i in bits [4i+3:4i] |
| test_en | input | 8 | Per-port test enable |
| gen_to_rx_en | input | 8 | Per-port route of generated values to the receive path |
| tst_wr | input | 1 | Processor write strobe for the test register |
| tst_port | input | 3 | Port addressed by the test write |
| tst_rts | input | 4 | Value carried by the test write |
| lb_en | input | 1 | Receive loopback enable |
| rx_valid | input | 1 | Received value strobe |
| rx_port | input | 3 | Port of the received value |
| rx_rts | input | 4 | Received value |
| pop | input | 1 | Frame generator pop request |
| pop_valid | output | 1 | Pop served this cycle |
| pop_port | output | 3 | Port of the head entry |
| pop_rts | output | 4 | Value of the head entry |
| rxp_valid | output | 1 | Generated value sent to the receive path |
| rxp_port | output | 3 | Port of the routed value |
| rxp_rts | output | 4 | Routed value |
| q_full | output | 1 | Queue holds 16 entries |
| q_empty | output | 1 | Queue holds no entry |
| overflow_flag | output | 1 | Sticky: write refused because the queue was full |
| underflow_flag | output | 1 | Sticky: pop on an empty queue |
| drop_flag | output | 9 | Sticky per-requester arbitration loss |

## Verification
The cycles of interest are those where a granted write and a pop happen together. This matters most at the boundaries: a pop from a full queue alongside a write that must still be refused, and a write into an empty queue alongside a pop that must still underflow. It also matters when several sources request in the same cycle, because one write is granted while losing requesters must set their drop bits. The random stimulus changes the pop probability in phases so that the queue repeatedly reaches both full and empty while all three sources request together. Directed cases force these collisions at each boundary. A bench model of the queue, the arbitration order and the sticky flags judges every cycle.

// File: rtl/rtsq_pkg.sv
package rtsq_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOOP = 2'd1,
    SRC_TEST = 2'd2,
    SRC_GEN  = 2'd3
  } src_e;

  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  function automatic int unsigned bit_slot(input int unsigned idx, input int unsigned w);
    return idx * w;
  endfunction

endpackage

// File: rtl/rtsq_gen_split.sv
module rtsq_gen_split #(
  parameter int NUM_PORTS = 8,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] gen_valid,
  input  logic [NUM_PORTS-1:0] test_en,
  input  logic [NUM_PORTS-1:0] to_rx,
  output logic [NUM_PORTS-1:0] fifo_req,
  output logic [NUM_PORTS-1:0] rx_req,
  output logic                 rx_win,
  output logic [PW-1:0]        rx_idx,
  output logic [NUM_PORTS-1:0] rx_lose
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    assign fifo_req[g] = gen_valid[g] & ~test_en[g] & ~to_rx[g];
    assign rx_req[g]   = gen_valid[g] & ~test_en[g] &  to_rx[g];

    p_test_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      test_en[g] |-> !fifo_req[g] && !rx_req[g]);
  end

  always_comb begin
    rx_win  = 1'b0;
    rx_idx  = '0;
    rx_lose = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (rx_req[i]) begin
        if (!rx_win) begin
          rx_win = 1'b1;
          rx_idx = PW'(i);
        end else begin
          rx_lose[i] = 1'b1;
        end
      end
    end
  end

  p_rx_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_win |-> !rx_lose[rx_idx] && rx_req[rx_idx]);

endmodule

// File: rtl/rtsq_push_arb.sv
module rtsq_push_arb
  import rtsq_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  localparam int PW = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lb_req,
  input  logic                 inj_req,
  input  logic [NUM_PORTS-1:0] gen_req,
  output src_e                 sel,
  output logic [PW-1:0]        gen_idx,
  output logic [NUM_PORTS-1:0] gen_lose,
  output logic                 inj_lose
);

  logic                 gen_any;
  logic [PW-1:0]        low_idx;
  logic [NUM_PORTS-1:0] low_mask;

  always_comb begin
    gen_any  = 1'b0;
    low_idx  = '0;
    low_mask = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (gen_req[i] && !gen_any) begin
        gen_any     = 1'b1;
        low_idx     = PW'(i);
        low_mask[i] = 1'b1;
      end
    end
  end

  always_comb begin
    sel      = SRC_NONE;
    gen_idx  = low_idx;
    gen_lose = gen_req;
    inj_lose = 1'b0;
    if (lb_req) begin
      sel      = SRC_LOOP;
      inj_lose = inj_req;
    end else if (inj_req) begin
      sel = SRC_TEST;
    end else if (gen_any) begin
      sel      = SRC_GEN;
      gen_lose = gen_req & ~low_mask;
    end
  end

  p_loop_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lb_req |-> sel == SRC_LOOP);
  p_test_over_gen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_req && inj_req) |-> sel == SRC_TEST && gen_lose == gen_req);
  p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_GEN) |-> $countones(gen_req & ~gen_lose) == 1);

endmodule

// File: rtl/rtsq_fifo.sv
module rtsq_fifo
  import rtsq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 7,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          pop_ok,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          push_rej,
  output logic          pop_rej
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_ok  = push & ~full;
  assign pop_ok   = pop & ~empty;
  assign push_rej = push & full;
  assign pop_rej  = pop & empty;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(wrap_inc(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(wrap_inc(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full && $stable(wr_ptr));
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop) |-> !pop_ok);
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

endmodule

// File: rtl/rts_tx_queue.sv
module rts_tx_queue
  import rtsq_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int RTS_W     = 4,
  parameter int DEPTH     = 16,
  localparam int PW = $clog2(NUM_PORTS),
  localparam int DW = PW + RTS_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       gen_valid,
  input  logic [NUM_PORTS*RTS_W-1:0] gen_rts,
  input  logic [NUM_PORTS-1:0]       test_en,
  input  logic [NUM_PORTS-1:0]       gen_to_rx_en,
  input  logic                       tst_wr,
  input  logic [PW-1:0]              tst_port,
  input  logic [RTS_W-1:0]           tst_rts,
  input  logic                       lb_en,
  input  logic                       rx_valid,
  input  logic [PW-1:0]              rx_port,
  input  logic [RTS_W-1:0]           rx_rts,
  input  logic                       pop,
  output logic                       pop_valid,
  output logic [PW-1:0]              pop_port,
  output logic [RTS_W-1:0]           pop_rts,
  output logic                       rxp_valid,
  output logic [PW-1:0]              rxp_port,
  output logic [RTS_W-1:0]           rxp_rts,
  output logic                       q_full,
  output logic                       q_empty,
  output logic                       overflow_flag,
  output logic                       underflow_flag,
  output logic [NUM_PORTS:0]         drop_flag
);

  logic [NUM_PORTS-1:0] fifo_req, rx_req, rx_lose, gen_lose;
  logic                 rx_win, inj_lose;
  logic [PW-1:0]        rx_idx, gen_idx;
  logic                 lb_req, inj_req;
  src_e                 sel;
  logic                 push;
  logic [DW-1:0]        push_data, head;
  logic                 push_rej, pop_rej;

  assign lb_req  = lb_en & rx_valid;
  assign inj_req = tst_wr & test_en[tst_port];

  rtsq_gen_split #(.NUM_PORTS(NUM_PORTS)) u_split (
    .clk(clk), .rst_n(rst_n),
    .gen_valid(gen_valid), .test_en(test_en), .to_rx(gen_to_rx_en),
    .fifo_req(fifo_req), .rx_req(rx_req),
    .rx_win(rx_win), .rx_idx(rx_idx), .rx_lose(rx_lose)
  );

  rtsq_push_arb #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .lb_req(lb_req), .inj_req(inj_req), .gen_req(fifo_req),
    .sel(sel), .gen_idx(gen_idx), .gen_lose(gen_lose), .inj_lose(inj_lose)
  );

  always_comb begin
    push      = 1'b1;
    push_data = '0;
    unique case (sel)
      SRC_LOOP: push_data = {rx_port, rx_rts};
      SRC_TEST: push_data = {tst_port, tst_rts};
      SRC_GEN:  push_data = {gen_idx, gen_rts[bit_slot(gen_idx, RTS_W) +: RTS_W]};
      default:  push = 1'b0;
    endcase
  end

  rtsq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_data), .pop(pop),
    .pop_ok(pop_valid), .rd_data(head),
    .full(q_full), .empty(q_empty),
    .push_rej(push_rej), .pop_rej(pop_rej)
  );

  assign pop_port  = head[DW-1 -: PW];
  assign pop_rts   = head[RTS_W-1:0];
  assign rxp_valid = rx_win;
  assign rxp_port  = rx_idx;
  assign rxp_rts   = gen_rts[bit_slot(rx_idx, RTS_W) +: RTS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow_flag  <= 1'b0;
      underflow_flag <= 1'b0;
      drop_flag      <= '0;
    end else begin
      overflow_flag  <= overflow_flag | push_rej;
      underflow_flag <= underflow_flag | pop_rej;
      drop_flag      <= drop_flag | {inj_lose, gen_lose | rx_lose};
    end
  end

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && push) |=> overflow_flag);
  p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_flag |=> underflow_flag);
  p_inj_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_req && inj_req) |=> drop_flag[NUM_PORTS]);
  p_route_not_queued_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_GEN) |-> !gen_to_rx_en[gen_idx]);

endmodule

// File: tb/test_rts_tx_queue.sv
module test_rts_tx_queue;

  localparam int NP = 8;
  localparam int QD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] gen_valid = '0, test_en = '0, gen_to_rx_en = '0;
  logic [NP*4-1:0] gen_rts = '0;
  logic tst_wr = 1'b0, lb_en = 1'b0, rx_valid = 1'b0, pop = 1'b0;
  logic [2:0] tst_port = '0, rx_port = '0;
  logic [3:0] tst_rts = '0, rx_rts = '0;
  logic pop_valid, rxp_valid, q_full, q_empty, overflow_flag, underflow_flag;
  logic [2:0] pop_port, rxp_port;
  logic [3:0] pop_rts, rxp_rts;
  logic [NP:0] drop_flag;

  always #10 clk = ~clk;

  rts_tx_queue i_rts_tx_queue (.*);

  int vectors = 0, errors = 0;
  logic [6:0] mq [QD];
  int m_cnt = 0, m_head = 0;
  logic m_ovf = 1'b0, m_udf = 1'b0;
  logic [NP:0] m_drop = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int low_set(input logic [NP-1:0] m);
    for (int i = 0; i < NP; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic run_cycle();
    logic inj, lbr, pv, ep;
    logic [NP-1:0] gq, gr, dg;
    logic [6:0] pd;
    int gl, rl;
    #2;
    inj = tst_wr && test_en[tst_port];
    lbr = lb_en && rx_valid;
    gq = gen_valid & ~test_en & ~gen_to_rx_en;
    gr = gen_valid & ~test_en & gen_to_rx_en;
    gl = low_set(gq);
    rl = low_set(gr);
    ep = 1'b1; pd = '0; dg = gq;
    if (lbr) pd = {rx_port, rx_rts};
    else if (inj) pd = {tst_port, tst_rts};
    else if (gl >= 0) begin
      pd = {3'(gl), gen_rts[gl*4 +: 4]};
      dg[gl] = 1'b0;
    end else ep = 1'b0;
    if (rl >= 0) dg = dg | (gr & ~(NP'(1) << rl));
    chk("R11 q_full", 32'(q_full), 32'(m_cnt == QD));
    chk("R11 q_empty", 32'(q_empty), 32'(m_cnt == 0));
    chk("R3 overflow_flag", 32'(overflow_flag), 32'(m_ovf));
    chk("R4 underflow_flag", 32'(underflow_flag), 32'(m_udf));
    chk("R9 drop_flag", 32'(drop_flag), 32'(m_drop));
    pv = pop && m_cnt > 0;
    chk(pv ? "R2 pop_valid" : "R4 pop_valid", 32'(pop_valid), 32'(pv));
    if (pv) chk("R2 pop entry", 32'({pop_port, pop_rts}), 32'(mq[m_head]));
    chk("R10 rxp_valid", 32'(rxp_valid), 32'(rl >= 0));
    if (rl >= 0) chk("R10 rxp entry", 32'({rxp_port, rxp_rts}), 32'({3'(rl), gen_rts[rl*4 +: 4]}));
    if (pop && m_cnt == 0) m_udf = 1'b1;
    if (ep && m_cnt == QD) m_ovf = 1'b1;
    m_drop = m_drop | {lbr && inj, dg};
    if (ep && m_cnt < QD) mq[(m_head + m_cnt) % QD] = pd;
    if (ep && m_cnt < QD) m_cnt++;
    if (pv) begin
      m_head = (m_head + 1) % QD;
      m_cnt--;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    gen_valid = '0; tst_wr = 1'b0; rx_valid = 1'b0; pop = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 q_empty", 32'(q_empty), 32'd1);
    chk("R1 flags", 32'({q_full, overflow_flag, underflow_flag, drop_flag}), 32'd0);
    pop = 1'b1;
    #2 chk("R1 pop_valid", 32'(pop_valid), 32'd0);
    run_cycle();
    idle();
    // R5 write to a port with test disabled is ignored
    tst_wr = 1'b1; tst_port = 3'd5; tst_rts = 4'hA;
    run_cycle();
    idle();
    #2 chk("R5 ignored write", 32'(q_empty), 32'd1);
    run_cycle();
    // R5 enabled test write and R6 discard of that port's generator
    test_en = 8'h20; tst_wr = 1'b1; tst_port = 3'd5; tst_rts = 4'h9;
    run_cycle();
    idle();
    gen_valid = 8'h20; gen_rts = 32'h00F0_0000;
    run_cycle();
    idle(); pop = 1'b1;
    #2 chk("R5 injected entry", 32'({pop_port, pop_rts}), 32'h59);
    run_cycle();
    idle();
    #2 chk("R6 generator discarded", 32'(q_empty), 32'd1);
    run_cycle();
    test_en = '0;
    // R7 loopback disabled vs enabled
    rx_valid = 1'b1; rx_port = 3'd2; rx_rts = 4'h3;
    run_cycle();
    #2 chk("R7 loopback off", 32'(q_empty), 32'd1);
    lb_en = 1'b1;
    run_cycle();
    idle();
    #2 chk("R7 loopback entry", 32'({pop_port, pop_rts}), 32'h23);
    pop = 1'b1;
    run_cycle();
    idle();
    // R8 all sources at once, loopback wins
    test_en = 8'h01; tst_wr = 1'b1; tst_port = 3'd0; tst_rts = 4'h4;
    rx_valid = 1'b1; rx_port = 3'd7; rx_rts = 4'hE; gen_valid = 8'h0C; gen_rts = 32'h0000_5600;
    run_cycle();
    idle();
    #2 chk("R8 loopback priority", 32'({pop_port, pop_rts}), 32'h7E);
    chk("R9 losers flagged", 32'(drop_flag), 32'h10C);
    pop = 1'b1;
    run_cycle();
    idle(); test_en = '0;
    // fill to full, then write and pop together while full (R3)
    for (int k = 0; k < QD + 1; k++) begin
      rx_valid = 1'b1; rx_port = 3'(k); rx_rts = 4'(k);
      run_cycle();
    end
    rx_valid = 1'b1; pop = 1'b1;
    run_cycle();
    idle();
    // drain past empty with a write at the same time (R4)
    for (int k = 0; k < QD + 2; k++) begin
      pop = 1'b1;
      run_cycle();
    end
    pop = 1'b1; rx_valid = 1'b1; rx_rts = 4'h1;
    run_cycle();
    idle();
    // R10 routing with two ports
    gen_to_rx_en = 8'h90; gen_valid = 8'h91; gen_rts = 32'h7000_0002;
    run_cycle();
    idle();
    // constrained random phases
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 400; c++) begin
        int pp;
        pp = (ph % 2 == 0) ? 20 : 80;
        gen_valid    = ($urandom % 3 == 0) ? 8'($urandom) : '0;
        gen_rts      = $urandom;
        test_en      = ($urandom % 4 == 0) ? 8'($urandom) : '0;
        gen_to_rx_en = 8'($urandom);
        tst_wr       = ($urandom % 4 == 0);
        tst_port     = 3'($urandom);
        tst_rts      = 4'($urandom);
        lb_en        = ($urandom % 2 == 0);
        rx_valid     = ($urandom % 4 == 0);
        rx_port      = 3'($urandom);
        rx_rts       = 4'($urandom);
        pop          = ($urandom % 100 < pp);
        run_cycle();
      end
    end
    idle();
    run_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule